// File: doc/BRIEF.md
# External Static Memory Access Sequencer with Wait States

This block carries single read and write transfers from an internal bus master to external static memory devices. The master raises a request with an address and a direction. The block captures them, decodes the chip select from the top address bits and drives the address, one active-low chip select per device, and separate active-low read and write strobes. When the transfer is finished it returns a one-cycle acknowledge. Setup and hold phases are zero cycles, so the strobe falls on the clock edge that starts the access.

Each chip select has its own configuration: a wait-state enable, a wait-state count and a flag that marks the device as one that uses the external wait input. With no wait states the strobe is low for half a clock cycle; the falling clock edge ends it. With N wait states the strobe is low for N full cycles. An asynchronous active-low wait input from the device passes through a two-stage synchronizer. While its synchronized value is low during the strobe phase, the access is frozen: outputs, counter and state keep their values. When the configuration pairs the external wait input with fewer than three wait states, a status flag is raised.

Top module: `ext_mem_seq`

## Requirements
- R1: While reset is asserted, both strobes and every chip select are high (inactive), and the acknowledge and the configuration flag are low.
- R2: During the strobe of an access, exactly one chip select is low: bit k of `mem_cs_n` for k = `req_addr[ADDR_W-1 -: CS_W]` (the top two bits by default). `mem_addr` equals the request address captured at acceptance.
- R3: Only the strobe for the access direction goes low (`req_write`=1 uses `mem_wr_n`, 0 uses `mem_rd_n`). With zero effective wait states that strobe is low for exactly half a clock cycle, from a rising edge to the next falling edge.
- R4: With an effective count of N ≥ 1 wait states, the strobe is low for exactly N clock cycles, starting at the rising edge that accepts the request.
- R5: When the wait-state enable of a chip select is 0, its wait-state count is ignored and the access behaves as with zero wait states.
- R6: `req_ack` is high for exactly one cycle, in the cycle after the strobe's last cycle. During that cycle the strobes and chip selects are inactive. No request is accepted again until the state after that cycle.
- R7: Changing `req_addr` while an access is in progress has no effect on `mem_addr` or on the chip selects.
- R8: For a chip select with the external wait use flag set and at least one wait state, each rising edge at which the two-stage-synchronized `ext_wait_n` is low during the strobe adds one cycle to the strobe. A low level driven half a cycle after the accepting edge and held for L cycles extends the strobe by L cycles.
- R9: For a chip select with the external wait use flag cleared, `ext_wait_n` has no effect on the strobe width.
- R10: `cfg_err` is updated at each accepted request: it becomes 1 when the selected chip select has the external wait use flag set and an effective wait count below 3, and 0 otherwise. It holds between requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; both edges are used for strobe timing |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the system |
| req_valid | input | 1 | Transfer request, held by the master until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address; top CS_W bits select the device |
| req_ack | output | 1 | One-cycle completion pulse |
| cfg_ws_en | input | NUM_CS | Per chip select wait-state enable |
| cfg_ws_cnt | input | NUM_CS*WS_W | Per chip select wait-state count, WS_W bits each, device k at bits k*WS_W upward |
| cfg_ext_en | input | NUM_CS | Per chip select external wait use flag |
| ext_wait_n | input | 1 | Asynchronous active-low wait from the device |
| mem_addr | output | ADDR_W | Address to the external device |
| mem_cs_n | output | NUM_CS | Active-low chip selects |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| cfg_err | output | 1 | Wait configuration too short for external wait use |

## Verification
The hardest case to set up from the ports is a freeze that starts and ends fully inside the strobe phase. The wait input is asynchronous and reaches the sequencer two edges late, so a low level applied too late or too early falls outside the phase or runs into the acknowledge. The bench drives `ext_wait_n` low half a cycle after the accepting edge, on a device with six wait states, and releases it a fixed number of falling edges later. This places every synchronized low sample between the third and the last strobe edge, so the expected strobe width and acknowledge cycle follow exactly. The same stimulus is repeated with the device's wait use flag cleared, to show that the input is then ignored.

// File: rtl/xsm_pkg.sv
`timescale 1ns/1ps
package xsm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/xsm_wait_sync.sv
`timescale 1ns/1ps
module xsm_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_n,
  output logic sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '1;
    else        sh_q <= sh_d;
  end

  assign sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/xsm_cfg_select.sv
`timescale 1ns/1ps
module xsm_cfg_select #(
  parameter int NUM_CS     = 4,
  parameter int WS_W       = 4,
  parameter int MIN_EXT_WS = 3,
  localparam int CS_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic [CS_W-1:0]        cs_idx,
  input  logic [NUM_CS-1:0]      cfg_ws_en,
  input  logic [NUM_CS*WS_W-1:0] cfg_ws_cnt,
  input  logic [NUM_CS-1:0]      cfg_ext_en,
  output logic [WS_W-1:0]        eff_ws,
  output logic                   ext_on,
  output logic                   cfg_bad
);
  logic [WS_W-1:0] cnt_arr [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign cnt_arr[g] = cfg_ws_cnt[g*WS_W +: WS_W];
  end

  always_comb begin
    eff_ws  = cfg_ws_en[cs_idx] ? cnt_arr[cs_idx] : '0;
    ext_on  = cfg_ext_en[cs_idx];
    cfg_bad = ext_on && (eff_ws < WS_W'(MIN_EXT_WS));
  end
endmodule

// File: rtl/xsm_access_fsm.sv
`timescale 1ns/1ps
module xsm_access_fsm
  import xsm_pkg::*;
#(
  parameter int WS_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [WS_W-1:0] eff_ws,
  input  logic            ext_on,
  input  logic            wait_low,
  output seq_state_e      state,
  output logic            accept,
  output logic            zero_ws
);
  seq_state_e      st_q, st_d;
  logic [WS_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            zero_q, ext_q;
  logic            hold;

  always_comb begin
    accept = (st_q == ST_IDLE) && req_valid;
    hold   = (st_q == ST_ACT) && ext_q && !zero_q && wait_low;
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (accept) begin
          st_d   = ST_ACT;
          cnt_d  = eff_ws;
          cnt_en = 1'b1;
        end
      end
      ST_ACT: begin
        if (zero_q) begin
          st_d = ST_FIN;
        end else if (!hold) begin
          if (cnt_q == WS_W'(1)) begin
            st_d = ST_FIN;
          end else begin
            cnt_d  = cnt_q - WS_W'(1);
            cnt_en = 1'b1;
          end
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      ext_q  <= 1'b0;
    end else if (accept) begin
      zero_q <= (eff_ws == '0);
      ext_q  <= ext_on;
    end
  end

  assign state   = st_q;
  assign zero_ws = zero_q;
endmodule

// File: rtl/xsm_strobe_gen.sv
`timescale 1ns/1ps
module xsm_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic zero_ws,
  input  logic write,
  output logic rd_n,
  output logic wr_n
);
  logic cut_q;
  logic cut_d;
  logic drive;

  always_comb begin
    cut_d = active && zero_ws;
  end

  // Falling-edge register ends a zero-wait strobe after half a cycle
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) cut_q <= 1'b0;
    else        cut_q <= cut_d;
  end

  always_comb begin
    drive = active && !cut_q;
    rd_n  = !(drive && !write);
    wr_n  = !(drive && write);
  end
endmodule

// File: rtl/ext_mem_seq.sv
`timescale 1ns/1ps
module ext_mem_seq
  import xsm_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int NUM_CS      = 4,
  parameter int WS_W        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_EXT_WS  = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  output logic                   req_ack,
  input  logic [NUM_CS-1:0]      cfg_ws_en,
  input  logic [NUM_CS*WS_W-1:0] cfg_ws_cnt,
  input  logic [NUM_CS-1:0]      cfg_ext_en,
  input  logic                   ext_wait_n,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [NUM_CS-1:0]      mem_cs_n,
  output logic                   mem_rd_n,
  output logic                   mem_wr_n,
  output logic                   cfg_err
);
  localparam int CS_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [CS_W-1:0]   req_cs;
  logic [WS_W-1:0]   eff_ws;
  logic              ext_on, cfg_bad;
  logic              wait_sync_n;
  seq_state_e        state;
  logic              accept, zero_ws, active;
  logic [ADDR_W-1:0] addr_q;
  logic [CS_W-1:0]   cs_q;
  logic              wr_q, err_q;

  assign req_cs = req_addr[ADDR_W-1 -: CS_W];

  xsm_cfg_select #(
    .NUM_CS(NUM_CS), .WS_W(WS_W), .MIN_EXT_WS(MIN_EXT_WS)
  ) cfg_sel_i (
    .cs_idx(req_cs), .cfg_ws_en(cfg_ws_en), .cfg_ws_cnt(cfg_ws_cnt),
    .cfg_ext_en(cfg_ext_en), .eff_ws(eff_ws), .ext_on(ext_on), .cfg_bad(cfg_bad)
  );

  xsm_wait_sync #(.STAGES(SYNC_STAGES)) wsync_i (
    .clk(clk), .rst_n(rst_n), .async_n(ext_wait_n), .sync_n(wait_sync_n)
  );

  xsm_access_fsm #(.WS_W(WS_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .eff_ws(eff_ws),
    .ext_on(ext_on), .wait_low(!wait_sync_n), .state(state),
    .accept(accept), .zero_ws(zero_ws)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cs_q   <= '0;
      wr_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      cs_q   <= req_cs;
      wr_q   <= req_write;
      err_q  <= cfg_bad;
    end
  end

  assign active = (state == ST_ACT);

  xsm_strobe_gen strobe_i (
    .clk(clk), .rst_n(rst_n), .active(active), .zero_ws(zero_ws),
    .write(wr_q), .rd_n(mem_rd_n), .wr_n(mem_wr_n)
  );

  always_comb begin
    mem_cs_n = '1;
    if (active) mem_cs_n[cs_q] = 1'b0;
  end

  assign mem_addr = addr_q;
  assign req_ack  = (state == ST_FIN);
  assign cfg_err  = err_q;
endmodule

// File: rtl/xsm_chk.sv
`timescale 1ns/1ps
module xsm_chk #(
  parameter int ADDR_W = 24,
  parameter int NUM_CS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [NUM_CS-1:0] mem_cs_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              cfg_err
);
  logic cs_act;
  assign cs_act = !(&mem_cs_n);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_n || mem_wr_n); // R3
  AST_CS_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n)); // R2
  AST_STROBE_WITH_CS: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd_n || !mem_wr_n) |-> ($countones(~mem_cs_n) == 1)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack); // R6
  AST_ACK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (mem_rd_n && mem_wr_n && !cs_act)); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && $past(cs_act)) |-> $stable(mem_addr)); // R7
  AST_ERR_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err != $past(cfg_err)) |-> cs_act); // R10
endmodule

bind ext_mem_seq xsm_chk #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ack(req_ack), .mem_addr(mem_addr),
  .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
  .cfg_err(cfg_err)
);

// File: tb/ext_mem_seq_tb_top.sv
`timescale 1ns/1ps
module ext_mem_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [23:0] req_addr = '0;
  logic        req_ack;
  logic [3:0]  cfg_ws_en = '0;
  logic [15:0] cfg_ws_cnt = '0;
  logic [3:0]  cfg_ext_en = '0;
  logic        ext_wait_n = 1'b1;
  logic [23:0] mem_addr;
  logic [3:0]  mem_cs_n;
  logic        mem_rd_n, mem_wr_n, cfg_err;

  int total = 0, bad = 0;
  bit done = 0;

  logic       b_en  [4] = '{1'b0, 1'b1, 1'b1, 1'b1};
  logic [3:0] b_cnt [4] = '{4'd5, 4'd0, 4'd1, 4'd6};
  logic       b_ext [4] = '{1'b0, 1'b0, 1'b1, 1'b1};

  // {cs[1:0], write, addr low byte}
  localparam logic [10:0] VEC [8] = '{
    {2'd0, 1'b0, 8'h11}, {2'd0, 1'b1, 8'h22}, {2'd1, 1'b0, 8'h33}, {2'd1, 1'b1, 8'h44},
    {2'd2, 1'b0, 8'h55}, {2'd2, 1'b1, 8'h66}, {2'd3, 1'b0, 8'h77}, {2'd3, 1'b1, 8'h88}
  };

  always #2 clk = ~clk;

  ext_mem_seq dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_ack(req_ack), .cfg_ws_en(cfg_ws_en),
    .cfg_ws_cnt(cfg_ws_cnt), .cfg_ext_en(cfg_ext_en), .ext_wait_n(ext_wait_n),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_wr_n(mem_wr_n), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_cfg();
    for (int g = 0; g < 4; g++) begin
      cfg_ws_en[g]          = b_en[g];
      cfg_ws_cnt[g*4 +: 4]  = b_cnt[g];
      cfg_ext_en[g]         = b_ext[g];
    end
  endtask

  function automatic int exp_ws(input int cs);
    return b_en[cs] ? int'(b_cnt[cs]) : 0;
  endfunction

  task automatic sample_phase(input logic [1:0] cs, input logic wr, input logic [23:0] a,
                              inout int halves, inout bit cs_ok, inout bit addr_ok, inout bit dir_ok);
    logic act_n, oth_n;
    act_n = wr ? mem_wr_n : mem_rd_n;
    oth_n = wr ? mem_rd_n : mem_wr_n;
    if (!oth_n) dir_ok = 0;
    if (!act_n) begin
      halves++;
      if (mem_cs_n != ~(4'b1 << cs)) cs_ok = 0;
      if (mem_addr != a) addr_ok = 0;
    end
  endtask

  task automatic run_access(input logic [1:0] cs, input logic wr, input logic [7:0] lo,
                            input int wstart, input int wlen, input bit scramble,
                            output int halves, output int ack_it,
                            output bit cs_ok, output bit addr_ok, output bit dir_ok);
    logic [23:0] a;
    a = {cs, 14'd0, lo};
    halves = 0; ack_it = -1; cs_ok = 1; addr_ok = 1; dir_ok = 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a;
    for (int i = 0; i < 100 && ack_it < 0; i++) begin
      @(posedge clk); #1;
      sample_phase(cs, wr, a, halves, cs_ok, addr_ok, dir_ok);
      if (req_ack) ack_it = i;
      @(negedge clk);
      if (scramble) req_addr = ~a;
      if (i == wstart) ext_wait_n = 1'b0;
      if (i == wstart + wlen) ext_wait_n = 1'b1;
      #1;
      sample_phase(cs, wr, a, halves, cs_ok, addr_ok, dir_ok);
    end
    req_valid = 1'b0;
    ext_wait_n = 1'b1;
    @(posedge clk); #1;
    chk(req_ack == 1'b0, "R6 ack lasts one cycle", req_ack, 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int h, ak, ws, exp_h, exp_ak;
    bit cok, aok, dok;
    string tag;
    apply_cfg();
    repeat (3) @(posedge clk);
    #1;
    chk(mem_rd_n && mem_wr_n, "R1 strobes idle in reset", {mem_rd_n, mem_wr_n}, 3);
    chk(mem_cs_n == 4'hF, "R1 chip selects idle in reset", mem_cs_n, 15);
    chk(!req_ack && !cfg_err, "R1 ack and flag low in reset", {req_ack, cfg_err}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // Table walk
    for (int v = 0; v < 8; v++) begin
      logic [1:0] cs; logic wr; logic [7:0] lo;
      {cs, wr, lo} = VEC[v];
      run_access(cs, wr, lo, 1000, 0, 1'b0, h, ak, cok, aok, dok);
      ws = exp_ws(cs);
      exp_h  = (ws == 0) ? 1 : 2 * ws;
      exp_ak = (ws == 0) ? 1 : ws;
      tag = (cs == 0) ? "R5 disabled count ignored" : ((ws == 0) ? "R3 half-cycle strobe" : "R4 strobe width");
      chk(h == exp_h, tag, h, exp_h);
      chk(ak == exp_ak, "R6 ack cycle", ak, exp_ak);
      chk(cok, "R2 chip select decode", cok, 1);
      chk(aok, "R2 address during strobe", aok, 1);
      chk(dok, "R3 opposite strobe stays high", dok, 1);
      chk(cfg_err == (b_ext[cs] && ws < 3), "R10 config flag", cfg_err, b_ext[cs] && ws < 3);
    end

    // R7: request address changes during the access
    run_access(2'd3, 1'b1, 8'hA5, 1000, 0, 1'b1, h, ak, cok, aok, dok);
    chk(aok, "R7 address held during access", aok, 1);
    chk(cok, "R7 chip select held during access", cok, 1);

    // R8: external wait freezes the strobe for four cycles
    run_access(2'd3, 1'b0, 8'h5A, 0, 4, 1'b0, h, ak, cok, aok, dok);
    chk(h == 2 * (6 + 4), "R8 strobe stretched by wait", h, 20);
    chk(ak == 6 + 4, "R8 ack delayed by wait", ak, 10);
    chk(aok && cok, "R8 outputs frozen during wait", aok && cok, 1);
    chk(cfg_err == 1'b0, "R10 flag clear for long count", cfg_err, 0);

    // R10: short count with wait use raises the flag
    run_access(2'd2, 1'b1, 8'h01, 1000, 0, 1'b0, h, ak, cok, aok, dok);
    chk(cfg_err == 1'b1, "R10 flag set for short count", cfg_err, 1);

    // R9: wait use cleared on the device, same wait stimulus
    b_ext[3] = 1'b0; apply_cfg();
    run_access(2'd3, 1'b1, 8'h02, 0, 4, 1'b0, h, ak, cok, aok, dok);
    chk(h == 12, "R9 wait ignored without use flag", h, 12);
    chk(ak == 6, "R9 ack not delayed", ak, 6);
    chk(cfg_err == 1'b0, "R10 flag clear without use flag", cfg_err, 0);
    b_ext[3] = 1'b1; apply_cfg();

    // R1: reset in the middle of an access
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = {2'd3, 22'd0};
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b0; #1;
    chk(mem_wr_n && mem_cs_n == 4'hF, "R1 reset aborts access", {mem_wr_n, mem_cs_n}, 31);
    chk(!cfg_err && !req_ack, "R1 reset clears flag and ack", {cfg_err, req_ack}, 0);
    req_valid = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule